// File: doc/BRIEF.md
# Scaled Index and Descending Stack Address Unit

This unit forms memory addresses for an execution pipeline. One path adds a base value to an index value that is first multiplied by 1, 2, 4 or 8. The index can also be updated as part of the same access, so that walking through an array needs no separate ALU operation. Three index behaviours are offered. The plain form leaves the index alone. The after-use increment form addresses with the old index and returns the index advanced by the step. The before-use decrement form lowers the index by the step first and addresses with the lowered value.

A second path keeps a stack pointer for a stack that grows toward lower addresses. The pointer always holds the address of the newest entry. A push strobe lowers the pointer and presents the lowered value as the write address in the same cycle. A pop strobe presents the current pointer as the read address and raises the pointer at the clock edge. Both paths compute combinationally and only the stack pointer and the error flag are stored. All arithmetic wraps modulo 2^AW.

Top module: `idxstk_agu`

## Requirements
- R1: `ea` equals `base` plus the selected index value times 2^`scale`, where the `scale` code 0, 1, 2, 3 selects the factor 1, 2, 4, 8.
- R2: With `mode` 2'b00 (plain), and with the reserved code 2'b11, `index_out` equals `index` and `ea` uses `index`.
- R3: With `mode` 2'b01 (increment after use), `ea` is formed from the incoming `index` and `index_out` equals `index + step`.
- R4: With `mode` 2'b10 (decrement before use), `index_out` equals `index - step` and `ea` is formed from that lowered value.
- R5: While `rst` is high at a clock edge, `sp` becomes the parameter `STACK_TOP` (default 16'h8000) and `stk_err` becomes 0.
- R6: A cycle with `push` high and `pop` low drives `stk_addr` to `sp - step` and `stk_act` high, and `sp` takes that value at the next rising edge.
- R7: A cycle with `pop` high and `push` low drives `stk_addr` to `sp` and `stk_act` high, and `sp` becomes `sp + step` at the next rising edge.
- R8: A cycle with both `push` and `pop` high keeps `stk_act` low, leaves `sp` unchanged, and makes `stk_err` high for exactly the following cycle; otherwise `stk_err` is low.
- R9: Index, address and stack pointer arithmetic all wrap modulo 2^AW with no saturation.
- R10: A cycle with neither strobe leaves `sp` unchanged and keeps `stk_act` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Index behaviour: 00 plain, 01 increment after use, 10 decrement before use, 11 plain |
| base | input | AW | Base address |
| index | input | AW | Current index value |
| scale | input | 2 | Index scale code, factor 2^scale |
| step | input | AW | Index update amount and stack move amount |
| push | input | 1 | Push strobe |
| pop | input | 1 | Pop strobe |
| ea | output | AW | Effective address of the indexed access |
| index_out | output | AW | Index value to write back |
| sp | output | AW | Stack pointer, address of the newest entry |
| stk_addr | output | AW | Address of the current push or pop access |
| stk_act | output | 1 | High when exactly one strobe is set |
| stk_err | output | 1 | One-cycle flag after a push and pop clash |

## Verification
The assertions assume that `push`, `pop`, `mode` and the data inputs are settled before each rising edge, and they take no position on the values driven during reset. The stimulus changes inputs only at the falling edge and holds the strobes low while reset is applied. Walking through every mode and scale code, through wrap-around operands, through push and pop bursts, through a forced clash and through a pseudo-random sequence keeps every property's antecedent reached from clean, post-reset states.

// File: rtl/idxstk_pkg.sv
package idxstk_pkg;

    typedef enum logic [1:0] {
        IXM_PLAIN   = 2'b00,
        IXM_POSTINC = 2'b01,
        IXM_PREDEC  = 2'b10,
        IXM_RSVD    = 2'b11
    } ix_mode_e;

    typedef enum logic [1:0] {
        STK_IDLE  = 2'b00,
        STK_PUSH  = 2'b01,
        STK_POP   = 2'b10,
        STK_CLASH = 2'b11
    } stk_op_e;

    localparam int unsigned SCALE_CODES = 4;

    function automatic stk_op_e stk_classify(input logic do_push, input logic do_pop);
        return stk_op_e'({do_pop, do_push});
    endfunction

endpackage

// File: rtl/idxstk_scaler.sv
module idxstk_scaler #(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0] val,
    input  logic [1:0]    code,
    output logic [AW-1:0] scaled
);
    import idxstk_pkg::*;

    logic [AW-1:0] shifted [SCALE_CODES];

    for (genvar g = 0; g < SCALE_CODES; g++) begin : g_shift
        assign shifted[g] = val << g;
    end

    assign scaled = shifted[code];

endmodule

// File: rtl/idxstk_index_unit.sv
module idxstk_index_unit #(
    parameter int unsigned AW = 16
) (
    input  logic [1:0]    mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] index,
    input  logic [1:0]    scale,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] index_out
);
    import idxstk_pkg::*;

    ix_mode_e      md;
    logic [AW-1:0] addr_idx;
    logic [AW-1:0] scaled_idx;

    assign md = ix_mode_e'(mode);

    always_comb begin
        addr_idx  = index;
        index_out = index;
        unique case (md)
            IXM_POSTINC: begin
                addr_idx  = index;
                index_out = index + step;
            end
            IXM_PREDEC: begin
                addr_idx  = index - step;
                index_out = index - step;
            end
            default: begin
                addr_idx  = index;
                index_out = index;
            end
        endcase
    end

    idxstk_scaler #(.AW(AW)) u_scaler (
        .val    (addr_idx),
        .code   (scale),
        .scaled (scaled_idx)
    );

    assign ea = base + scaled_idx;

endmodule

// File: rtl/idxstk_stack_unit.sv
module idxstk_stack_unit #(
    parameter int unsigned       AW        = 16,
    parameter logic [AW-1:0]     STACK_TOP = 16'h8000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] stk_addr,
    output logic          stk_act,
    output logic          stk_err
);
    import idxstk_pkg::*;

    stk_op_e       op;
    logic [AW-1:0] sp_lower;
    logic [AW-1:0] sp_upper;
    logic [AW-1:0] sp_nxt;

    assign op       = stk_classify(push, pop);
    assign sp_lower = sp - step;
    assign sp_upper = sp + step;

    always_comb begin
        sp_nxt   = sp;
        stk_addr = sp;
        stk_act  = 1'b0;
        unique case (op)
            STK_PUSH: begin
                sp_nxt   = sp_lower;
                stk_addr = sp_lower;
                stk_act  = 1'b1;
            end
            STK_POP: begin
                sp_nxt   = sp_upper;
                stk_addr = sp;
                stk_act  = 1'b1;
            end
            default: begin
                sp_nxt   = sp;
                stk_addr = sp;
                stk_act  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp      <= STACK_TOP;
            stk_err <= 1'b0;
        end else begin
            sp      <= sp_nxt;
            stk_err <= (op == STK_CLASH);
        end
    end

    a_r5_reset_top: assert property (@(posedge clk) rst |=> (sp == STACK_TOP && !stk_err));

    a_r6_push_lowers: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> (sp == $past(sp) - $past(step)));

    a_r7_pop_raises: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> (sp == $past(sp) + $past(step)));

    a_r8_clash_holds: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> ($stable(sp) && stk_err));

    a_r8_err_only_after_clash: assert property (@(posedge clk) disable iff (rst)
        !(push && pop) |=> !stk_err);

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!push && !pop) |=> $stable(sp));

endmodule

// File: rtl/idxstk_agu.sv
module idxstk_agu #(
    parameter int unsigned   AW        = 16,
    parameter logic [AW-1:0] STACK_TOP = 16'h8000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] index,
    input  logic [1:0]    scale,
    input  logic [AW-1:0] step,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] index_out,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] stk_addr,
    output logic          stk_act,
    output logic          stk_err
);

    idxstk_index_unit #(.AW(AW)) u_index (
        .mode      (mode),
        .base      (base),
        .index     (index),
        .scale     (scale),
        .step      (step),
        .ea        (ea),
        .index_out (index_out)
    );

    idxstk_stack_unit #(.AW(AW), .STACK_TOP(STACK_TOP)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .step     (step),
        .sp       (sp),
        .stk_addr (stk_addr),
        .stk_act  (stk_act),
        .stk_err  (stk_err)
    );

    // Index path: output relations checked against the unit's inputs
    a_r2_plain_keeps_index: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 || mode == 2'b11) |-> (index_out == index));

    a_r3_postinc_advance: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01) |-> (index_out == index + step && ea == base + (index << scale)));

    a_r4_predec_lowered: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10) |-> (index_out == index - step && ea == base + (index_out << scale)));

    a_r6_push_addr: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> (stk_act && stk_addr == sp - step));

    a_r7_pop_addr: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |-> (stk_act && stk_addr == sp));

endmodule

// File: tb/idxstk_agu_tb.sv
`timescale 1ns/1ps
module idxstk_agu_tb;

    localparam int unsigned AW  = 16;
    localparam logic [15:0] TOP = 16'h8000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = '0;
    logic [AW-1:0] base = '0, index = '0, step = '0;
    logic [1:0]    scale = '0;
    logic          push = 1'b0, pop = 1'b0;
    logic [AW-1:0] ea, index_out, sp, stk_addr;
    logic          stk_act, stk_err;

    int checks = 0;
    int fails  = 0;

    logic [15:0] m_sp  = TOP;
    logic        m_err = 1'b0;

    always #4 clk = ~clk;

    idxstk_agu #(.AW(AW), .STACK_TOP(TOP)) u_dut (
        .clk(clk), .rst(rst), .mode(mode), .base(base), .index(index),
        .scale(scale), .step(step), .push(push), .pop(pop),
        .ea(ea), .index_out(index_out), .sp(sp), .stk_addr(stk_addr),
        .stk_act(stk_act), .stk_err(stk_err)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model at the rising edge
    task automatic cyc(input logic [1:0] m, input logic [15:0] b, input logic [15:0] i,
                       input logic [1:0] s, input logic [15:0] st,
                       input logic pu, input logic po);
        logic [15:0] use_idx, exp_ix, exp_ea;
        mode = m; base = b; index = i; scale = s; step = st; push = pu; pop = po;
        #1;
        case (m)
            2'b01:   begin use_idx = i;      exp_ix = i + st; end
            2'b10:   begin use_idx = i - st; exp_ix = i - st; end
            default: begin use_idx = i;      exp_ix = i;      end
        endcase
        exp_ea = b + use_idx * (16'd1 << s);
        case (m)
            2'b01:   begin chk("R3 index_out", index_out, exp_ix); chk("R1 R3 ea", ea, exp_ea); end
            2'b10:   begin chk("R4 index_out", index_out, exp_ix); chk("R1 R4 ea", ea, exp_ea); end
            default: begin chk("R2 index_out", index_out, exp_ix); chk("R1 R2 ea", ea, exp_ea); end
        endcase
        chk("R6 R7 R10 sp", sp, m_sp);
        chk("R8 stk_err", {15'd0, stk_err}, {15'd0, m_err});
        chk("R8 R10 stk_act", {15'd0, stk_act}, {15'd0, pu ^ po});
        if (pu && !po) chk("R6 stk_addr", stk_addr, m_sp - st);
        if (po && !pu) chk("R7 stk_addr", stk_addr, m_sp);
        @(posedge clk);
        if (pu && !po)      m_sp = m_sp - st;
        else if (po && !pu) m_sp = m_sp + st;
        m_err = pu && po;
        @(negedge clk);
    endtask

    task automatic do_reset();
        push = 1'b0; pop = 1'b0; rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R5 sp", sp, TOP);
        chk("R5 stk_err", {15'd0, stk_err}, 16'd0);
        m_sp = TOP; m_err = 1'b0;
        rst = 1'b0;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        do_reset();

        // Every mode and scale, normal and wrapping operands (R1-related sweep, R9 wrap)
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 4; s++) begin
                cyc(2'(m), 16'h1000, 16'h0010, 2'(s), 16'h0003, 1'b0, 1'b0);
                cyc(2'(m), 16'hFFF0, 16'h0004, 2'(s), 16'h0001, 1'b0, 1'b0);
                cyc(2'(m), 16'h0200, 16'h0000, 2'(s), 16'h0002, 1'b0, 1'b0); // R9 predec wrap
                cyc(2'(m), 16'h0000, 16'hFFFF, 2'(s), 16'h0001, 1'b0, 1'b0); // R9 postinc wrap
            end
        end

        // Push burst then pop burst (R6, R7)
        for (int k = 0; k < 6; k++) cyc(2'b01, 16'h0, 16'(k), 2'd1, 16'h0002, 1'b1, 1'b0);
        for (int k = 0; k < 6; k++) cyc(2'b10, 16'h0, 16'(k), 2'd2, 16'h0002, 1'b0, 1'b1);

        // Clash: pointer holds, error one cycle (R8), then idle (R10)
        cyc(2'b00, 16'h0, 16'h0, 2'd0, 16'h0004, 1'b1, 1'b0);
        cyc(2'b00, 16'h0, 16'h0, 2'd0, 16'h0004, 1'b1, 1'b1);
        cyc(2'b00, 16'h0, 16'h0, 2'd0, 16'h0004, 1'b0, 1'b0);
        cyc(2'b00, 16'h0, 16'h0, 2'd0, 16'h0004, 1'b0, 1'b0);
        cyc(2'b00, 16'h0, 16'h0, 2'd0, 16'h0004, 1'b1, 1'b1);
        cyc(2'b00, 16'h0, 16'h0, 2'd0, 16'h0004, 1'b1, 1'b1);
        cyc(2'b00, 16'h0, 16'h0, 2'd0, 16'h0004, 1'b0, 1'b1);

        // Stack pointer wrap (R9): reach 0 by popping, then push below it
        do_reset();
        cyc(2'b00, 16'h0, 16'h0, 2'd0, 16'h8000, 1'b0, 1'b1);
        cyc(2'b00, 16'h0, 16'h0, 2'd0, 16'h0002, 1'b1, 1'b0);
        cyc(2'b00, 16'h0, 16'h0, 2'd0, 16'h0002, 1'b0, 1'b1);
        cyc(2'b00, 16'h0, 16'h0, 2'd0, 16'h0002, 1'b0, 1'b0);

        // Pseudo-random mix
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[1:0], lfsr ^ 16'h5A5A, {lfsr[7:0], lfsr[15:8]}, lfsr[3:2],
                {12'd0, lfsr[7:4]}, lfsr[8], lfsr[9] & lfsr[10]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule